// File: doc/BRIEF.md
# Completion Status Ring Writer

This engine posts finished-command records into a circular ring of status slots that lives in host memory. The controller core offers one record at a time: a command identifier, an 8-bit status, an 8-bit request-sense length and a 32-bit data-transfer residue. The engine writes each record into the current slot through a single-outstanding memory port. It then steps its slot pointer, returning to the first slot after the last one, and raises a sticky status-available event. The host clears that event through its doorbell logic.

No head or tail registers exist. A slot holds a valid entry while its identifier is nonzero, and the host gives a slot back by writing zero to its head word. Before each post the engine reads the head word of the target slot. While that word reads nonzero the ring is full, so the engine holds its input stalled and reads again. Each entry is written residue first and head word last, so the host never sees a valid identifier beside a stale residue.

Top module: `cring_status_writer`

## Requirements
- R1: After reset, cpl_ready, mem_req and stat_avail are low, and the first post targets slot 0 (address cfg_base).
- R2: An entry occupies 8 bytes. The head word at the slot address is {sense[31:24], status[23:16], id[15:0]}, and the residue word sits at slot address + 4.
- R3: Within one post the residue word is written before the head word, and no other write falls between them.
- R4: Before it accepts a record, the engine issues a read of the target slot's head word. cpl_ready rises for one cycle only after such a read has returned zero.
- R5: A nonzero head-word read leaves cpl_ready low and produces no write. The engine reads the same address again until it returns zero.
- R6: Slot k sits at cfg_base + 8*k. The pointer advances by one after each post and wraps from slot cfg_slots-1 to slot 0.
- R7: stat_avail goes high once the head-word write of a post completes, and it stays high until stat_ack is asserted.
- R8: When stat_ack arrives in the same cycle as a completing post, stat_avail stays high.
- R9: Once mem_req is raised it stays high, with mem_addr, mem_we and mem_wdata unchanged, until mem_ack is seen.
- R10: stat_ack in a cycle with no completing post clears stat_avail on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | AW | Byte address of slot 0 (8-byte aligned) |
| cfg_slots | input | SLOT_W | Number of slots in the ring (at least 1) |
| cpl_valid | input | 1 | Completion record offered; held until accepted |
| cpl_ready | output | 1 | Record accepted this cycle |
| cpl_id | input | 16 | Command identifier (nonzero) |
| cpl_status | input | 8 | Command status |
| cpl_sense | input | 8 | Request-sense length |
| cpl_residue | input | 32 | Data-transfer residue |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle completion of the pending access |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| stat_avail | output | 1 | Sticky status-available event |
| stat_ack | input | 1 | Clears stat_avail |

## Verification
The hardest state to reach is a full ring. The host model never consumes on its own, so the bench posts as many entries as there are slots. The next record then finds a nonzero head word in slot 0. The bench holds the record for many cycles and confirms that cpl_ready stays low and no write appears while the engine keeps re-reading. Only then does it zero the slot, which lets the post complete at the wrapped address. A second hard case holds stat_ack high throughout a post, so the acknowledge and the new event meet in the same cycle.

// File: rtl/cring_pkg.sv
package cring_pkg;

  localparam int ENTRY_SHIFT = 3;
  localparam int TAIL_OFS    = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROBE,
    ST_TAKE,
    ST_TAIL,
    ST_HEAD
  } post_state_t;

  typedef struct packed {
    logic [15:0] id;
    logic [7:0]  status;
    logic [7:0]  sense;
    logic [31:0] residue;
  } cpl_rec_t;

  function automatic logic [31:0] head_word(input cpl_rec_t r);
    return {r.sense, r.status, r.id};
  endfunction

endpackage

// File: rtl/cring_slot_ptr.sv
module cring_slot_ptr #(
  parameter int SLOT_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic [SLOT_W-1:0] cfg_slots,
  output logic [SLOT_W-1:0] ptr
);

  logic [SLOT_W-1:0] ptr_q, ptr_d;
  logic              at_last;

  assign at_last = (ptr_q == (cfg_slots - SLOT_W'(1)));

  always_comb begin
    ptr_d = ptr_q;
    if (advance) begin
      if (at_last) ptr_d = '0;
      else         ptr_d = ptr_q + SLOT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= '0;
    else if (advance) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R6: the pointer only moves on a post, by one step or back to zero
  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q != $past(ptr_q)) |->
      ($past(advance) && ((ptr_q == $past(ptr_q) + SLOT_W'(1)) || (ptr_q == '0))));

endmodule

// File: rtl/cring_post_fsm.sv
module cring_post_fsm
  import cring_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpl_valid,
  input  cpl_rec_t      cpl_rec,
  output logic          cpl_ready,
  input  logic [AW-1:0] slot_addr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          posted
);

  post_state_t state_q, state_d;
  cpl_rec_t    rec_q, rec_d;
  logic        rec_en;

  always_comb begin
    state_d = state_q;
    rec_en  = 1'b0;
    rec_d   = cpl_rec;
    unique case (state_q)
      ST_IDLE:  if (cpl_valid) state_d = ST_PROBE;
      ST_PROBE: if (mem_ack) state_d = (mem_rdata == '0) ? ST_TAKE : ST_PROBE;
      ST_TAKE: begin
        if (cpl_valid) begin
          rec_en  = 1'b1;
          state_d = ST_TAIL;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_TAIL:  if (mem_ack) state_d = ST_HEAD;
      ST_HEAD:  if (mem_ack) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rec_q <= '0;
    else if (rec_en) rec_q <= rec_d;
  end

  always_comb begin
    mem_req   = (state_q == ST_PROBE) || (state_q == ST_TAIL) || (state_q == ST_HEAD);
    mem_we    = (state_q == ST_TAIL) || (state_q == ST_HEAD);
    mem_addr  = (state_q == ST_TAIL) ? (slot_addr + AW'(TAIL_OFS)) : slot_addr;
    mem_wdata = (state_q == ST_TAIL) ? rec_q.residue : head_word(rec_q);
  end

  assign cpl_ready = (state_q == ST_TAKE);
  assign posted    = (state_q == ST_HEAD) && mem_ack;

  // R9: a pending request is held unchanged until acknowledged
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R4: acceptance only right after a zero head-word read
  assert_accept_after_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_ready |-> $past(mem_req && mem_ack && !mem_we && (mem_rdata == '0)));

  // R5: an occupied slot never leads to acceptance or a write next cycle
  assert_full_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !mem_we && (mem_rdata != '0)) |=> (!cpl_ready && !mem_we));

  // R3: the head-word write immediately follows the residue write
  assert_head_after_tail_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack && (mem_addr == slot_addr + AW'(TAIL_OFS))) |=>
      (mem_req && mem_we && (mem_addr == slot_addr)));

endmodule

// File: rtl/cring_evt.sv
module cring_evt (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic ack,
  output logic avail
);

  logic avail_q, avail_d;

  always_comb begin
    avail_d = avail_q;
    if (ack) avail_d = 1'b0;
    if (set) avail_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) avail_q <= 1'b0;
    else        avail_q <= avail_d;
  end

  assign avail = avail_q;

  // R7: sticky without an acknowledge
  assert_evt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (avail_q && !ack) |=> avail_q);

  // R8: a post wins over a simultaneous acknowledge
  assert_evt_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> avail_q);

  // R10: a lone acknowledge clears
  assert_evt_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !set) |=> !avail_q);

endmodule

// File: rtl/cring_status_writer.sv
module cring_status_writer
  import cring_pkg::*;
#(
  parameter int AW        = 32,
  parameter int MAX_SLOTS = 256,
  parameter int SLOT_W    = $clog2(MAX_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     cfg_base,
  input  logic [SLOT_W-1:0] cfg_slots,
  input  logic              cpl_valid,
  output logic              cpl_ready,
  input  logic [15:0]       cpl_id,
  input  logic [7:0]        cpl_status,
  input  logic [7:0]        cpl_sense,
  input  logic [31:0]       cpl_residue,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              stat_avail,
  input  logic              stat_ack
);

  logic [SLOT_W-1:0] ptr;
  logic [AW-1:0]     slot_addr;
  logic              posted;
  cpl_rec_t          rec_in;

  assign rec_in    = '{id: cpl_id, status: cpl_status, sense: cpl_sense, residue: cpl_residue};
  assign slot_addr = cfg_base + (AW'(ptr) << ENTRY_SHIFT);

  cring_slot_ptr #(.SLOT_W(SLOT_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance   (posted),
    .cfg_slots (cfg_slots),
    .ptr       (ptr)
  );

  cring_post_fsm #(.AW(AW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpl_valid (cpl_valid),
    .cpl_rec   (rec_in),
    .cpl_ready (cpl_ready),
    .slot_addr (slot_addr),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .posted    (posted)
  );

  cring_evt u_evt (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (posted),
    .ack   (stat_ack),
    .avail (stat_avail)
  );

  // R6: the target slot always lies inside the configured ring
  assert_slot_in_ring_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_slots != '0) |-> (ptr < cfg_slots));

  // R2: a head-word write always carries a nonzero identifier
  assert_head_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && (mem_addr == slot_addr)) |-> (mem_wdata[15:0] != '0));

endmodule

// File: tb/tb_cring_status_writer.sv
module tb_cring_status_writer;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 32;
  localparam int SLOT_W     = 9;
  localparam logic [31:0] BASE = 32'h20;
  localparam int SLOTS      = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cpl_valid, cpl_ready;
  logic [15:0]       cpl_id;
  logic [7:0]        cpl_status, cpl_sense;
  logic [31:0]       cpl_residue;
  logic              mem_req, mem_we, mem_ack;
  logic [AW-1:0]     mem_addr;
  logic [31:0]       mem_wdata, mem_rdata;
  logic              stat_avail, stat_ack;

  int errors = 0;
  int checks = 0;
  int wr_count = 0;
  int exp_ptr = 0;
  logic [31:0] probe_exp;
  logic [63:0] exp_q[$];
  logic        host_clr;
  logic [5:0]  host_idx;
  logic [31:0] mem [0:63];
  logic        prev_pend;
  logic [AW-1:0] prev_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  cring_status_writer #(.AW(AW), .MAX_SLOTS(256), .SLOT_W(SLOT_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_base(BASE), .cfg_slots(SLOT_W'(SLOTS)),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_id(cpl_id),
    .cpl_status(cpl_status), .cpl_sense(cpl_sense), .cpl_residue(cpl_residue),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .stat_avail(stat_avail), .stat_ack(stat_ack)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // host memory model: one-cycle registered acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      for (int i = 0; i < 64; i++) mem[i] <= '0;
    end else begin
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
        else        mem_rdata <= mem[mem_addr[7:2]];
      end else begin
        mem_ack <= 1'b0;
      end
      if (host_clr) mem[host_idx] <= '0;
    end
  end

  // scoreboard monitor, sampling between edges
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_pend)
        check(mem_req && (mem_addr == prev_addr), "R9 request held", {32'b0, mem_addr}, {32'b0, prev_addr});
      if (mem_req && !mem_ack) begin
        if (mem_we) begin
          wr_count++;
          if (exp_q.size() == 0) begin
            check(1'b0, "R3/R5 unexpected write", {mem_addr, mem_wdata}, 64'h0);
          end else begin
            logic [63:0] e;
            e = exp_q.pop_front();
            check({mem_addr, mem_wdata} == e, "R2/R3/R6 write addr,data", {mem_addr, mem_wdata}, e);
          end
        end else begin
          check(mem_addr == probe_exp, "R4 probe address", {32'b0, mem_addr}, {32'b0, probe_exp});
        end
      end
      prev_pend = mem_req && !mem_ack;
      prev_addr = mem_addr;
    end else begin
      prev_pend = 1'b0;
    end
  end

  task automatic push_exp(input logic [15:0] id, input logic [7:0] st, input logic [7:0] sn, input logic [31:0] res);
    logic [31:0] sa;
    sa = BASE + 32'(exp_ptr * 8);
    exp_q.push_back({sa + 32'd4, res});
    exp_q.push_back({sa, sn, st, id});
  endtask

  task automatic drive_rec(input logic [15:0] id, input logic [7:0] st, input logic [7:0] sn, input logic [31:0] res);
    cpl_id = id; cpl_status = st; cpl_sense = sn; cpl_residue = res;
    cpl_valid = 1'b1;
  endtask

  task automatic handshake_and_drain();
    while (!cpl_ready) @(negedge clk);
    @(negedge clk);
    cpl_valid = 1'b0;
    while (exp_q.size() != 0 || mem_req) @(negedge clk);
    exp_ptr = (exp_ptr + 1) % SLOTS;
    @(negedge clk);
  endtask

  task automatic post(input logic [15:0] id, input logic [7:0] st, input logic [7:0] sn, input logic [31:0] res);
    probe_exp = BASE + 32'(exp_ptr * 8);
    push_exp(id, st, sn, res);
    drive_rec(id, st, sn, res);
    handshake_and_drain();
  endtask

  task automatic host_release(input int slot);
    host_idx = 6'((BASE >> 2) + 32'(slot * 2));
    host_clr = 1'b1;
    @(negedge clk);
    host_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int w0;
    rst_n = 1'b0; cpl_valid = 1'b0; stat_ack = 1'b0; host_clr = 1'b0; host_idx = '0;
    cpl_id = '0; cpl_status = '0; cpl_sense = '0; cpl_residue = '0; probe_exp = BASE;
    prev_pend = 1'b0; prev_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!cpl_ready && !mem_req && !stat_avail, "R1 idle after reset",
          {61'b0, cpl_ready, mem_req, stat_avail}, 64'h0);

    // first post goes to slot 0 (R1, R2, R3)
    post(16'h0001, 8'h00, 8'h00, 32'h0000_0200);
    check(stat_avail == 1'b1, "R7 event after post", {63'b0, stat_avail}, 64'h1);
    repeat (5) @(negedge clk);
    check(stat_avail == 1'b1, "R7 event sticky", {63'b0, stat_avail}, 64'h1);
    stat_ack = 1'b1;
    @(negedge clk);
    stat_ack = 1'b0;
    check(stat_avail == 1'b0, "R10 acknowledge clears", {63'b0, stat_avail}, 64'h0);

    // fill remaining slots with varied patterns (R2, R6)
    post(16'hFFFF, 8'hFF, 8'hFF, 32'hFFFF_FFFF);
    post(16'h1234, 8'h02, 8'h12, 32'h0000_0000);
    post(16'h8000, 8'h5A, 8'hA5, 32'hDEAD_BEEF);
    check(stat_avail == 1'b1, "R7 event after back-to-back posts", {63'b0, stat_avail}, 64'h1);

    // ring full: slot 0 still holds a valid entry (R5)
    probe_exp = BASE;
    drive_rec(16'h0042, 8'h07, 8'h08, 32'h0000_1111);
    w0 = wr_count;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (cpl_ready) check(1'b0, "R5 ready while full", 64'h1, 64'h0);
    end
    check(wr_count == w0, "R5 no write while full", 64'(wr_count), 64'(w0));
    // release slot 0; post lands there after wrap (R6)
    push_exp(16'h0042, 8'h07, 8'h08, 32'h0000_1111);
    host_release(0);
    handshake_and_drain();
    check(exp_ptr == 1, "R6 wrapped to slot 0", 64'(exp_ptr), 64'h1);

    // acknowledge coinciding with a completing post (R8)
    stat_ack = 1'b1;
    @(negedge clk);
    check(stat_avail == 1'b0, "R10 cleared before overlap test", {63'b0, stat_avail}, 64'h0);
    host_release(1);
    probe_exp = BASE + 32'd8;
    push_exp(16'h0077, 8'h01, 8'h00, 32'h0000_0044);
    drive_rec(16'h0077, 8'h01, 8'h00, 32'h0000_0044);
    while (!cpl_ready) @(negedge clk);
    @(negedge clk);
    cpl_valid = 1'b0;
    while (!(mem_ack && mem_we && (mem_addr == BASE + 32'd8))) @(negedge clk);
    @(negedge clk);
    check(stat_avail == 1'b1, "R8 post wins over acknowledge", {63'b0, stat_avail}, 64'h1);
    stat_ack = 1'b0;
    @(negedge clk);
    check(stat_avail == 1'b1, "R7 sticky after overlap", {63'b0, stat_avail}, 64'h1);
    exp_ptr = 2;

    // slot 2 still occupied; release it and post again (R5, R6)
    host_release(2);
    post(16'h0003, 8'h10, 8'h20, 32'h0000_0300);
    check(mem[(BASE >> 2) + 4] == {8'h20, 8'h10, 16'h0003}, "R2 head word in memory",
          {32'b0, mem[(BASE >> 2) + 4]}, {32'b0, 8'h20, 8'h10, 16'h0003});
    check(exp_q.size() == 0, "R3 all expected writes seen", 64'(exp_q.size()), 64'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule